// File: doc/BRIEF.md
# Bursty Pulse-Wave Event Generator

This block produces timed stimulus events for a device under test. Time is measured in ticks from a programmable prescaler. The ticks are grouped into repeating periods, and one burst window opens at the start of each period. Inside the window the block issues event strobes at a programmable spacing. Outside the window it stays silent, which models the dormant stretches between bursts.

Every event carries a pseudo-random payload, for example a key code or a GPIO pattern. It also carries the timestamp of the tick on which it fired, so a downstream driver can apply the vector at the right moment. The same pseudo-random source adds a bounded jitter to each spacing.

The period, burst length, spacing and jitter range are runtime inputs. They are captured at each period boundary, so a change made mid-period takes effect cleanly on the next period.

Top module: `pulse_wave_gen`

## Requirements
- R1: Once running, the block produces one tick every `prescale`+1 clock cycles while `enable` is high. A `prescale` change takes effect at once. `timestamp` starts at 0 after reset, rises by exactly one per tick, and is never cleared at a period boundary.
- R2: Within a period, ticks are numbered 0 to P-1. With zero jitter, events fire on ticks 0, S, 2S and so on, up to but not including the effective burst length. No event fires on any other tick, and the pattern repeats every P ticks.
- R3: Each event is a `ev_strobe` pulse lasting one clock, in the cycle after its tick. `ev_time` equals the `timestamp` value that the tick carried before it incremented.
- R4: `ev_payload` follows a 16-bit Galois LFSR. The seed is 0xACE1 after reset. Each step shifts the register right by one and, when the bit shifted out was 1, XORs the result with 0xB400. The register steps exactly once per event, and the payload of the n-th event after reset is the n-th state, counting the seed as state 0.
- R5: After an event at tick t of a period, the next event is due at tick t + S + (payload & (2^J − 1)), where J is the value of `jitter_cfg` (0 to 15).
- R6: A burst length greater than the period is clamped to the period. A spacing of 0 is treated as 1, and a period of 0 is treated as 1. A burst length of 0 gives no events at all.
- R7: Values on `period_cfg`, `burst_cfg`, `space_cfg` and `jitter_cfg` are captured only when the generator starts and at each period wrap. A change made mid-period does not alter the remaining events of that period.
- R8: The first rising of `enable` after reset starts the generator at tick 0 of a period. While `enable` is low, no strobe is produced, `timestamp` and all counters hold, and `burst_active` is low. Raising `enable` again resumes from the held position.
- R9: `burst_active` is high exactly while the generator is running and the current period tick is below the effective burst length.
- R10: The 16-bit counters cover spacing/burst/period settings of 25/500/1000 ticks and of 1/10/1000 ticks, producing 20 and 10 events per period respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run/hold control |
| prescale | input | PW (16) | Clock cycles per tick, minus one |
| period_cfg | input | CW (16) | Period length P in ticks |
| burst_cfg | input | CW (16) | Burst window length in ticks |
| space_cfg | input | CW (16) | Event spacing S in ticks |
| jitter_cfg | input | JW (4) | Jitter range as a bit count J |
| ev_strobe | output | 1 | One-clock event pulse |
| ev_payload | output | LW (16) | Pseudo-random payload of the latest event |
| ev_time | output | TW (32) | Tick timestamp of the latest event |
| burst_active | output | 1 | High while inside the burst window |
| timestamp | output | TW (32) | Free-running tick count |

## Verification
Some properties are checked on every cycle by the assertions:
- `timestamp` only ever steps by one.
- The LFSR never reaches zero.
- The period position stays below the captured period.
- Every strobe fires inside the burst window, with `ev_time` one behind `timestamp`.
- No strobe follows a cycle in which `enable` was low.

Other behaviour can only be shown by the bench's scenarios, which compare each event time against a closed-form expression of period, burst and spacing:
- the exact event schedule;
- burst clamping and zero-spacing handling;
- the jitter relation between consecutive events;
- parameter capture at the period boundary;
- resumption after a hold.

// File: rtl/pulse_wave_gen.sv
module pulse_wave_gen #(
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int TW = 32,
  parameter int LW = 16,
  parameter logic [LW-1:0] SEED = 16'hACE1,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  localparam int JW = $clog2(LW),
  localparam int NW = ((CW > LW) ? CW : LW) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [PW-1:0] prescale,
  input  logic [CW-1:0] period_cfg,
  input  logic [CW-1:0] burst_cfg,
  input  logic [CW-1:0] space_cfg,
  input  logic [JW-1:0] jitter_cfg,
  output logic          ev_strobe,
  output logic [LW-1:0] ev_payload,
  output logic [TW-1:0] ev_time,
  output logic          burst_active,
  output logic [TW-1:0] timestamp
);

  logic          started;
  logic [PW-1:0] presc_cnt;
  logic [CW-1:0] pos, per_sh, bur_sh, spc_sh;
  logic [JW-1:0] jit_sh;
  logic [NW-1:0] next_ev;
  logic [LW-1:0] lfsr;

  wire [CW-1:0] per_eff  = (per_sh == '0) ? CW'(1) : per_sh;
  wire [CW-1:0] bur_eff  = (bur_sh > per_eff) ? per_eff : bur_sh;
  wire [CW-1:0] spc_eff  = (spc_sh == '0) ? CW'(1) : spc_sh;
  wire [LW-1:0] jit_mask = (LW'(1) << jit_sh) - LW'(1);
  wire          in_burst = pos < bur_eff;
  wire          running  = started && enable;
  wire          tick     = running && (presc_cnt == prescale);
  wire          fire     = tick && in_burst && (NW'(pos) == next_ev);
  wire          last     = (pos == per_eff - CW'(1));
  wire [LW-1:0] lfsr_nxt = lfsr[0] ? ((lfsr >> 1) ^ TAPS) : (lfsr >> 1);
  wire [NW-1:0] next_due = NW'(pos) + NW'(spc_eff) + NW'(lfsr & jit_mask);

  assign burst_active = running && in_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started    <= 1'b0;
      presc_cnt  <= '0;
      pos        <= '0;
      per_sh     <= '0;
      bur_sh     <= '0;
      spc_sh     <= '0;
      jit_sh     <= '0;
      next_ev    <= '0;
      lfsr       <= SEED;
      ev_strobe  <= 1'b0;
      ev_payload <= '0;
      ev_time    <= '0;
      timestamp  <= '0;
    end else begin
      ev_strobe <= fire;
      if (fire) begin
        ev_payload <= lfsr;
        ev_time    <= timestamp;
        lfsr       <= lfsr_nxt;
      end
      if (enable && !started) begin
        started   <= 1'b1;
        presc_cnt <= '0;
        pos       <= '0;
        next_ev   <= '0;
        per_sh    <= period_cfg;
        bur_sh    <= burst_cfg;
        spc_sh    <= space_cfg;
        jit_sh    <= jitter_cfg;
      end else if (running) begin
        if (tick) begin
          presc_cnt <= '0;
          timestamp <= timestamp + TW'(1);
          if (last) begin
            pos     <= '0;
            next_ev <= '0;
            per_sh  <= period_cfg;
            bur_sh  <= burst_cfg;
            spc_sh  <= space_cfg;
            jit_sh  <= jitter_cfg;
          end else begin
            pos <= pos + CW'(1);
            if (fire) next_ev <= next_due;
          end
        end else begin
          presc_cnt <= presc_cnt + PW'(1);
        end
      end
    end
  end

  assert_ts_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (timestamp != $past(timestamp)) |-> (timestamp == $past(timestamp) + TW'(1)));

  assert_event_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe |-> $past(burst_active));

  assert_event_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe |-> (ev_time == timestamp - TW'(1)));

  assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  assert_no_event_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ev_strobe);

  assert_pos_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (pos < per_eff));

endmodule

// File: tb/test_pulse_wave_gen.sv
module test_pulse_wave_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] prescale = '0;
  logic [15:0] period_cfg = '0, burst_cfg = '0, space_cfg = '0;
  logic [3:0]  jitter_cfg = '0;
  logic        ev_strobe, burst_active;
  logic [15:0] ev_payload;
  logic [31:0] ev_time, timestamp;

  pulse_wave_gen i_pulse_wave_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
    .period_cfg(period_cfg), .burst_cfg(burst_cfg), .space_cfg(space_cfg),
    .jitter_cfg(jitter_cfg), .ev_strobe(ev_strobe), .ev_payload(ev_payload),
    .ev_time(ev_time), .burst_active(burst_active), .timestamp(timestamp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  int mode = 0;
  int cP = 1, cB = 0, cS = 1, cE = 1, cJ = 0;
  int ev_cnt = 0, time_err = 0, pay_err = 0, ba_cnt = 0, jit_seen = 0;
  longint first_act = 0, first_exp = 0;
  longint prev_time = 0;
  logic [15:0] prev_pay = '0;
  logic [15:0] ref_lfsr = 16'hACE1;
  longint logt [32];

  function automatic logic [15:0] lfsr_step(input logic [15:0] v);
    return v[0] ? ((v >> 1) ^ 16'hB400) : (v >> 1);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (burst_active) ba_cnt++;
      if (ev_strobe) begin
        longint exp_t;
        if (ev_payload != ref_lfsr) pay_err++;
        ref_lfsr = lfsr_step(ref_lfsr);
        if (mode == 0) begin
          exp_t = (ev_cnt / cE) * cP + (ev_cnt % cE) * cS;
          if (ev_time != exp_t) begin
            if (time_err == 0) begin first_act = ev_time; first_exp = exp_t; end
            time_err++;
          end
        end else if (mode == 1) begin
          if ((ev_time % cP) >= cB) begin
            if (time_err == 0) begin first_act = ev_time % cP; first_exp = cB - 1; end
            time_err++;
          end else if ((ev_time % cP) != 0) begin
            exp_t = prev_time + cS + (prev_pay & ((16'd1 << cJ) - 16'd1));
            if (exp_t != prev_time + cS) jit_seen++;
            if (ev_time != exp_t) begin
              if (time_err == 0) begin first_act = ev_time; first_exp = exp_t; end
              time_err++;
            end
          end
          prev_time = ev_time;
          prev_pay  = ev_payload;
        end else begin
          if (ev_cnt < 32) logt[ev_cnt] = ev_time;
        end
        ev_cnt++;
      end
    end
  end

  task automatic setup(input int p, input int b, input int s, input int j, input int pr, input int md);
    rst_n = 1'b0; enable = 1'b0;
    period_cfg = 16'(p); burst_cfg = 16'(b); space_cfg = 16'(s);
    jitter_cfg = 4'(j); prescale = 16'(pr);
    mode = md;
    cP = (p == 0) ? 1 : p;
    cB = (b > cP) ? cP : b;
    cS = (s == 0) ? 1 : s;
    cJ = j;
    cE = (cB == 0) ? 1 : (cB + cS - 1) / cS;
    ev_cnt = 0; time_err = 0; pay_err = 0; ba_cnt = 0; jit_seen = 0;
    first_act = 0; first_exp = 0; prev_time = 0; prev_pay = '0;
    ref_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_to(input int target);
    enable = 1'b1;
    while (timestamp != 32'(target)) @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c0;
    int c1;

    // Reset state
    setup(10, 5, 1, 0, 0, 0);
    check(ev_strobe == 1'b0, "R3 reset strobe", ev_strobe, 0);
    check(timestamp == 0, "R1 reset timestamp", timestamp, 0);
    check(burst_active == 1'b0, "R9 reset burst_active", burst_active, 0);
    check(ev_payload == 0, "R4 reset payload", ev_payload, 0);

    // R10 / R2: spacing 25, burst 500, period 1000
    setup(1000, 500, 25, 0, 0, 0);
    run_to(2000);
    check(ev_cnt == 40, "R10 event count 25/500/1000", ev_cnt, 40);
    check(time_err == 0, "R2 event times 25/500/1000", first_act, first_exp);
    check(pay_err == 0, "R4 payload sequence", pay_err, 0);
    check(ba_cnt == 1000, "R9 burst_active cycles", ba_cnt, 1000);

    // R10: spacing 1, burst 10, period 1000
    setup(1000, 10, 1, 0, 0, 0);
    run_to(2000);
    check(ev_cnt == 20, "R10 event count 1/10/1000", ev_cnt, 20);
    check(time_err == 0, "R2 event times 1/10/1000", first_act, first_exp);

    // R6: burst clamped to period
    setup(8, 20, 3, 0, 0, 0);
    run_to(24);
    check(ev_cnt == 9, "R6 clamp count", ev_cnt, 9);
    check(time_err == 0, "R6 clamp times", first_act, first_exp);

    // R6: zero spacing treated as one
    setup(10, 4, 0, 0, 0, 0);
    run_to(30);
    check(ev_cnt == 12, "R6 zero spacing count", ev_cnt, 12);
    check(time_err == 0, "R6 zero spacing times", first_act, first_exp);

    // R6: zero burst gives no events
    setup(10, 0, 2, 0, 0, 0);
    run_to(30);
    check(ev_cnt == 0, "R6 zero burst events", ev_cnt, 0);
    check(ba_cnt == 0, "R9 zero burst active", ba_cnt, 0);

    // R5: jitter
    setup(200, 150, 4, 3, 0, 1);
    run_to(600);
    check(ev_cnt > 10, "R5 jitter events present", ev_cnt, 11);
    check(time_err == 0, "R5 jitter spacing", first_act, first_exp);
    check(jit_seen > 0, "R5 jitter observed", jit_seen, 1);
    check(pay_err == 0, "R4 payload under jitter", pay_err, 0);

    // R1 / R9: prescaler and burst window
    setup(20, 5, 2, 0, 9, 0);
    enable = 1'b1;
    while (timestamp != 1) @(negedge clk);
    c0 = 0;
    while (timestamp != 11) begin @(negedge clk); c0++; end
    check(c0 == 100, "R1 cycles per 10 ticks", c0, 100);
    while (timestamp != 13) @(negedge clk);
    check(burst_active == 1'b0, "R9 outside burst", burst_active, 0);
    while (timestamp != 22) @(negedge clk);
    check(burst_active == 1'b1, "R9 second period in burst", burst_active, 1);
    run_to(40);
    check(ev_cnt == 6, "R2 count with prescaler", ev_cnt, 6);
    check(time_err == 0, "R2 times with prescaler", first_act, first_exp);

    // R7: parameter change mid-period
    setup(10, 10, 5, 0, 0, 2);
    enable = 1'b1;
    while (timestamp != 3) @(negedge clk);
    space_cfg = 16'd2;
    run_to(30);
    check(ev_cnt == 12, "R7 event count", ev_cnt, 12);
    c1 = 0;
    for (int k = 0; k < 12; k++) begin
      longint e;
      e = (k < 2) ? k * 5 : 10 + (k - 2) * 2;
      if (logt[k] != e && c1 == 0) begin
        c1 = 1;
        check(1'b0, "R7 event time", logt[k], e);
      end
    end
    if (c1 == 0) check(1'b1, "R7 event time", 0, 0);

    // R8: hold and resume
    setup(10, 10, 1, 0, 0, 2);
    run_to(15);
    c0 = ev_cnt;
    c1 = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (ev_strobe) c1++;
    end
    check(c1 == 0, "R8 no strobe while held", c1, 0);
    check(timestamp == 15, "R8 timestamp held", timestamp, 15);
    check(burst_active == 1'b0, "R8 burst_active low while held", burst_active, 0);
    check(c0 == 15, "R8 events before hold", c0, 15);
    run_to(20);
    check(ev_cnt == 20 && logt[15] == 15, "R8 resume time", logt[15], 15);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule